// File: doc/BRIEF.md
# Synchronous Burst SRAM with Wrapping Address Counter

This block is a clocked static RAM with an 18-bit word made of two 9-bit byte lanes. Every input except output enable is captured on the rising clock edge. An access is either a fresh start, which loads an external base address, or a continuation, which reuses or advances a 2-bit counter that drives only the lowest two address bits. The counter wraps modulo four relative to the loaded start value. The upper address bits stay as loaded.

There are two active-low start strobes. The processor-side strobe always starts a read and has priority. The controller-side strobe starts a read or a write, depending on the lane write enables. Chip enable is looked at only when a start strobe is low. If it is high in that cycle, the block goes deselected. A continuation cycle advances the counter when the advance input is low and reuses the current address when it is high, which inserts a wait state. A write through the processor-side strobe takes two cycles: the strobe with the address, then a suspended continuation that carries the write enables and the data.

The bidirectional data bus is split into a data input, a data output and an output-enable flag. Read data appears one clock edge after the edge that sampled the access. The address width is a parameter so that simulation can use a small array.

Top module: `bsram_top`

## Requirements
- R1: After reset the block is idle with `dout_en_o` low, and continuation cycles produce no read output until a start strobe loads a base address.
- R2: With `ce_n_i` low and `ps_n_i` low, the block loads `addr_i` and performs a read; `cs_n_i` and `we_n_i` have no effect in that cycle.
- R3: With `ce_n_i` low, `cs_n_i` low and `ps_n_i` high, the block loads `addr_i` and writes if any bit of `we_n_i` is low; otherwise it reads.
- R4: A low start strobe with `ce_n_i` high deselects the block: no access is made, and later continuation cycles do nothing. `ce_n_i` has no effect in continuation cycles.
- R5: In a continuation cycle (both strobes high) with `adv_n_i` low, the low two address bits are incremented modulo 4 before the access and the upper bits keep their loaded value, so the fifth access of a burst returns to the start word.
- R6: In a continuation cycle with `adv_n_i` high, the access reuses the current address.
- R7: A start strobe sampled low during a burst abandons that burst and starts at the new external address.
- R8: `we_n_i[0]` low writes data bits 8:0, and `we_n_i[1]` low writes bits 17:9. Each lane is written independently.
- R9: A two-cycle write works: `ps_n_i` low with the address, then a cycle with both strobes high, `adv_n_i` high, write enables low and the data. This writes the loaded address.
- R10: `dout_en_o` is high only when the previous edge performed a read and `oe_n_i` is low. `oe_n_i` acts combinationally. `dout_o` is zero whenever `dout_en_o` is low.
- R11: Read data for an access sampled on edge N is presented on `dout_o` after edge N+1 and is held until edge N+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | External word address |
| din_i | input | 18 | Write data |
| ce_n_i | input | 1 | Chip enable, active low, sampled on start cycles |
| ps_n_i | input | 1 | Processor-side start strobe, active low |
| cs_n_i | input | 1 | Controller-side start strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| we_n_i | input | 2 | Lane write enables, active low; bit 0 lower lane, bit 1 upper lane |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| dout_o | output | 18 | Read data, zero when not driven |
| dout_en_o | output | 1 | High when the data output is driven |

## Verification
The hardest state to reach from the ports is a counter wrap that is combined with a wait state and then cut off by a new start strobe. Reaching it needs a known start offset, several advances, a suspend, and an interrupting load, all in one run. The stimulus table first fills four adjacent words with distinct values through a controller-started write burst. It then reads them back from a mid-group offset so that the wrap, the suspend and the interruption each show a different word. Lane masking and the two-cycle write are checked by overwriting words that are already known, so that a wrong lane or a wrong address gives a visible mismatch.

// File: rtl/bsram_pkg.sv
// Package with the shared types and helpers of the burst SRAM.
// Assumes a 2-bit burst counter on the lowest address bits.
package bsram_pkg;

    // Kind of cycle decoded from the strobes sampled at a clock edge.
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_LOAD  = 2'd1,
        CYC_CONT  = 2'd2,
        CYC_DESEL = 2'd3
    } cyc_kind_e;

    localparam int BURST_BITS = 2;

    // Next low-address value: hold on a wait state, else step modulo 4.
    function automatic logic [BURST_BITS-1:0] step_low(
        input logic [BURST_BITS-1:0] cur,
        input logic                  hold
    );
        return hold ? cur : cur + {{(BURST_BITS-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/bsram_cycle_decode.sv
// Combinational decode of the start strobes, chip enable and lane
// write enables into a cycle kind and a per-lane write mask.
// Assumes the processor-side strobe has priority and always reads.
module bsram_cycle_decode
    import bsram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             ce_n_i,
    input  logic             ps_n_i,
    input  logic             cs_n_i,
    input  logic             active_i,
    input  logic [LANES-1:0] we_n_i,
    output cyc_kind_e        kind_o,
    output logic             wr_o,
    output logic [LANES-1:0] lane_we_o
);

    logic any_lane;

    // Pick the cycle kind and whether it writes.
    always_comb begin
        any_lane = ~&we_n_i;
        if (!ps_n_i || !cs_n_i) begin
            kind_o = ce_n_i ? CYC_DESEL : CYC_LOAD;
        end else begin
            kind_o = active_i ? CYC_CONT : CYC_IDLE;
        end
        wr_o = ((kind_o == CYC_LOAD) && ps_n_i && any_lane) ||
               ((kind_o == CYC_CONT) && any_lane);
        lane_we_o = wr_o ? ~we_n_i : '0;
    end

endmodule

// File: rtl/bsram_burst_seq.sv
// Burst address sequencer: holds the loaded base, the 2-bit counter and
// the burst-active flag, and registers one access per clock edge.
// Assumes ADDR_W > 2; only the low two bits ever change within a burst.
module bsram_burst_seq
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W,
    localparam int HI_W   = ADDR_W - BURST_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_kind_e         kind_i,
    input  logic              wr_i,
    input  logic [LANES-1:0]  lane_we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              adv_n_i,
    output logic              active_o,
    output logic              acc_vld_o,
    output logic              acc_wr_o,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic [DATA_W-1:0] acc_data_o,
    output logic [LANES-1:0]  acc_lane_o
);

    logic [HI_W-1:0]       base_hi_q;
    logic [BURST_BITS-1:0] cnt_q;
    logic [BURST_BITS-1:0] cnt_nxt;

    // Counter value used by a continuation cycle.
    always_comb cnt_nxt = step_low(cnt_q, adv_n_i);

    // Burst state and the registered access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o   <= 1'b0;
            base_hi_q  <= '0;
            cnt_q      <= '0;
            acc_vld_o  <= 1'b0;
            acc_wr_o   <= 1'b0;
            acc_addr_o <= '0;
            acc_data_o <= '0;
            acc_lane_o <= '0;
        end else begin
            case (kind_i)
                CYC_LOAD: begin
                    active_o   <= 1'b1;
                    base_hi_q  <= addr_i[ADDR_W-1:BURST_BITS];
                    cnt_q      <= addr_i[BURST_BITS-1:0];
                    acc_vld_o  <= 1'b1;
                    acc_wr_o   <= wr_i;
                    acc_addr_o <= addr_i;
                    acc_data_o <= din_i;
                    acc_lane_o <= lane_we_i;
                end
                CYC_CONT: begin
                    cnt_q      <= cnt_nxt;
                    acc_vld_o  <= 1'b1;
                    acc_wr_o   <= wr_i;
                    acc_addr_o <= {base_hi_q, cnt_nxt};
                    acc_data_o <= din_i;
                    acc_lane_o <= lane_we_i;
                end
                CYC_DESEL: begin
                    active_o   <= 1'b0;
                    acc_vld_o  <= 1'b0;
                    acc_wr_o   <= 1'b0;
                    acc_lane_o <= '0;
                end
                default: begin
                    acc_vld_o  <= 1'b0;
                    acc_wr_o   <= 1'b0;
                    acc_lane_o <= '0;
                end
            endcase
        end
    end

    // R5
    advance_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == CYC_CONT && !adv_n_i) |=>
            (acc_addr_o[BURST_BITS-1:0] ==
                 $past(acc_addr_o[BURST_BITS-1:0]) + 2'd1) &&
            (acc_addr_o[ADDR_W-1:BURST_BITS] ==
                 $past(acc_addr_o[ADDR_W-1:BURST_BITS])));

    // R6
    suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == CYC_CONT && adv_n_i) |=>
            (acc_addr_o == $past(acc_addr_o)));

    // R7
    load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == CYC_LOAD) |=> (acc_vld_o && acc_addr_o == $past(addr_i)));

endmodule

// File: rtl/bsram_array.sv
// Storage array split into byte lanes, with a per-lane write mask and
// a registered read port. Assumes a read and a write never share a cycle.
module bsram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_vld_i,
    input  logic              acc_wr_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [DATA_W-1:0] acc_data_i,
    input  logic [LANES-1:0]  acc_lane_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_vld_o
);

    logic do_read;

    // A read happens for every valid access that does not write.
    always_comb do_read = acc_vld_i && !acc_wr_i;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];
        logic [LANE_W-1:0] rd_q;

        // Write this lane when its mask bit is set.
        always_ff @(posedge clk) begin
            if (acc_vld_i && acc_wr_i && acc_lane_i[g]) begin
                mem_q[acc_addr_i] <= acc_data_i[g*LANE_W +: LANE_W];
            end
        end

        // Capture this lane's read data.
        always_ff @(posedge clk) begin
            if (do_read) begin
                rd_q <= mem_q[acc_addr_i];
            end
        end

        assign rd_data_o[g*LANE_W +: LANE_W] = rd_q;
    end

    // Flag marking that the read register holds fresh data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld_o <= 1'b0;
        end else begin
            rd_vld_o <= do_read;
        end
    end

    // R10
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld_i && acc_wr_i) |=> !rd_vld_o);

endmodule

// File: rtl/bsram_top.sv
// Synchronous burst SRAM top: strobe decode, burst sequencer, lane
// array, and output gating by the asynchronous output enable.
// Assumes the bidirectional bus is split outside this block.
module bsram_top
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              ce_n_i,
    input  logic              ps_n_i,
    input  logic              cs_n_i,
    input  logic              adv_n_i,
    input  logic [LANES-1:0]  we_n_i,
    input  logic              oe_n_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dout_en_o
);

    cyc_kind_e         kind;
    logic              wr;
    logic [LANES-1:0]  lane_we;
    logic              active;
    logic              acc_vld;
    logic              acc_wr;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_data;
    logic [LANES-1:0]  acc_lane;
    logic [DATA_W-1:0] rd_data;
    logic              rd_vld;

    bsram_cycle_decode #(.LANES(LANES)) u_decode (
        .ce_n_i    (ce_n_i),
        .ps_n_i    (ps_n_i),
        .cs_n_i    (cs_n_i),
        .active_i  (active),
        .we_n_i    (we_n_i),
        .kind_o    (kind),
        .wr_o      (wr),
        .lane_we_o (lane_we)
    );

    bsram_burst_seq #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind_i     (kind),
        .wr_i       (wr),
        .lane_we_i  (lane_we),
        .addr_i     (addr_i),
        .din_i      (din_i),
        .adv_n_i    (adv_n_i),
        .active_o   (active),
        .acc_vld_o  (acc_vld),
        .acc_wr_o   (acc_wr),
        .acc_addr_o (acc_addr),
        .acc_data_o (acc_data),
        .acc_lane_o (acc_lane)
    );

    bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_vld_i  (acc_vld),
        .acc_wr_i   (acc_wr),
        .acc_addr_i (acc_addr),
        .acc_data_i (acc_data),
        .acc_lane_i (acc_lane),
        .rd_data_o  (rd_data),
        .rd_vld_o   (rd_vld)
    );

    // Drive the outputs only for fresh read data with output enable low.
    always_comb begin
        dout_en_o = rd_vld && !oe_n_i;
        dout_o    = dout_en_o ? rd_data : '0;
    end

    // R2
    pstart_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ps_n_i && !ce_n_i) |=> ##1 (rd_vld || !rst_n));

    // R3
    cstart_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_i && ps_n_i && !ce_n_i && we_n_i != '1) |=> ##1 !dout_en_o);

    // R4
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n_i && (!ps_n_i || !cs_n_i)) |=> ##1 !dout_en_o);

endmodule

// File: tb/bsram_top_bench.sv
module bsram_top_bench;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 18;

    typedef struct packed {
        logic        ce_n;
        logic        ps_n;
        logic        cs_n;
        logic        adv_n;
        logic        oe_n;
        logic [1:0]  we_n;
        logic [7:0]  addr;
        logic [17:0] din;
        logic        exp_en;
        logic [17:0] exp_d;
        logic [7:0]  req;
    } vec_t;

    localparam logic [17:0] D10 = 18'h10A5A;
    localparam logic [17:0] D11 = 18'h2C3C3;
    localparam logic [17:0] D12 = 18'h0F0F0;
    localparam logic [17:0] D13 = 18'h31234;
    localparam logic [17:0] DNW = 18'h25B6D;
    localparam logic [17:0] DLN = 18'h001FF;
    localparam logic [17:0] Z18 = 18'h00000;

    localparam int NVEC = 28;
    // Expectations describe the outputs seen after that row's edge,
    // which carry the read sampled by the previous row.
    localparam vec_t VEC [NVEC] = '{
        // R1: continuation cycles before any load
        '{1'b0,1'b1,1'b1,1'b0,1'b0,2'b11,8'h00,Z18, 1'b0,Z18, 8'd1},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,2'b00,8'h00,Z18, 1'b0,Z18, 8'd1},
        // R3: controller-started write burst over 0x10..0x13
        '{1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,8'h10,D10, 1'b0,Z18, 8'd3},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,2'b00,8'h00,D11, 1'b0,Z18, 8'd3},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,2'b00,8'h00,D12, 1'b0,Z18, 8'd3},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,2'b00,8'h00,D13, 1'b0,Z18, 8'd3},
        // R2: processor start reads at 0x12; enables and cs ignored
        '{1'b0,1'b0,1'b0,1'b1,1'b0,2'b00,8'h12,18'h3FFFF, 1'b0,Z18, 8'd2},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,2'b11,8'h00,Z18, 1'b1,D12, 8'd11},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,2'b11,8'h00,Z18, 1'b1,D13, 8'd5},
        // R6: suspend keeps the wrapped address 0x10
        '{1'b0,1'b1,1'b1,1'b1,1'b0,2'b11,8'h00,Z18, 1'b1,D10, 8'd5},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,2'b11,8'h00,Z18, 1'b1,D10, 8'd6},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,2'b11,8'h00,Z18, 1'b1,D11, 8'd5},
        // R10: output enable high hides read data
        '{1'b0,1'b1,1'b1,1'b0,1'b1,2'b11,8'h00,Z18, 1'b0,Z18, 8'd10},
        // R4: deselect with processor strobe and ce high
        '{1'b1,1'b0,1'b1,1'b1,1'b0,2'b11,8'h11,Z18, 1'b1,D13, 8'd5},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,2'b11,8'h00,Z18, 1'b0,Z18, 8'd4},
        // R8: lower lane then upper lane at 0x11
        '{1'b0,1'b1,1'b0,1'b1,1'b0,2'b10,8'h11,18'h3FFFF, 1'b0,Z18, 8'd4},
        '{1'b0,1'b1,1'b1,1'b1,1'b0,2'b01,8'h00,Z18, 1'b0,Z18, 8'd8},
        '{1'b0,1'b1,1'b0,1'b1,1'b0,2'b11,8'h11,Z18, 1'b0,Z18, 8'd8},
        '{1'b0,1'b1,1'b1,1'b1,1'b0,2'b11,8'h00,Z18, 1'b1,DLN, 8'd8},
        // R9: two-cycle write at 0x10 started by processor strobe
        '{1'b0,1'b0,1'b1,1'b1,1'b0,2'b00,8'h10,18'h3FFFF, 1'b1,DLN, 8'd3},
        '{1'b0,1'b1,1'b1,1'b1,1'b0,2'b00,8'h00,DNW, 1'b1,D10, 8'd2},
        '{1'b0,1'b1,1'b0,1'b1,1'b0,2'b11,8'h10,Z18, 1'b0,Z18, 8'd9},
        '{1'b0,1'b1,1'b1,1'b1,1'b0,2'b11,8'h00,Z18, 1'b1,DNW, 8'd9},
        // R7: interrupt a burst with a new start at 0x13
        '{1'b0,1'b1,1'b1,1'b0,1'b0,2'b11,8'h00,Z18, 1'b1,DNW, 8'd9},
        '{1'b0,1'b1,1'b0,1'b1,1'b0,2'b11,8'h13,Z18, 1'b1,DLN, 8'd5},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,2'b11,8'h00,Z18, 1'b1,D13, 8'd7},
        // R4: ce high on a continuation cycle has no effect
        '{1'b1,1'b1,1'b1,1'b1,1'b0,2'b11,8'h00,Z18, 1'b1,DNW, 8'd5},
        '{1'b0,1'b1,1'b1,1'b1,1'b0,2'b11,8'h00,Z18, 1'b1,DNW, 8'd4}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] din = '0;
    logic              ce_n = 1'b1;
    logic              ps_n = 1'b1;
    logic              cs_n = 1'b1;
    logic              adv_n = 1'b1;
    logic [1:0]        we_n = 2'b11;
    logic              oe_n = 1'b0;
    logic [DATA_W-1:0] dout;
    logic              dout_en;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    bsram_top u_bsram_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr),
        .din_i     (din),
        .ce_n_i    (ce_n),
        .ps_n_i    (ps_n),
        .cs_n_i    (cs_n),
        .adv_n_i   (adv_n),
        .we_n_i    (we_n),
        .oe_n_i    (oe_n),
        .dout_o    (dout),
        .dout_en_o (dout_en)
    );

    task automatic check(input string tag, input logic e_en, input logic [17:0] e_d);
        n_chk++;
        if (dout_en !== e_en || dout !== e_d) begin
            n_bad++;
            $display("FAIL %s: en=%0b dout=%05h expected en=%0b dout=%05h",
                     tag, dout_en, dout, e_en, e_d);
        end
    endtask

    task automatic idle_inputs();
        ce_n = 1'b0; ps_n = 1'b1; cs_n = 1'b1; adv_n = 1'b1;
        we_n = 2'b11; oe_n = 1'b0; addr = '0; din = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", 1'b0, Z18);
        rst_n = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            ce_n = VEC[i].ce_n; ps_n = VEC[i].ps_n; cs_n = VEC[i].cs_n;
            adv_n = VEC[i].adv_n; oe_n = VEC[i].oe_n; we_n = VEC[i].we_n;
            addr = VEC[i].addr; din = VEC[i].din;
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d row %0d", VEC[i].req, i), VEC[i].exp_en, VEC[i].exp_d);
        end
        // R10: output enable acts without a clock edge
        idle_inputs();
        @(posedge clk);
        @(negedge clk);
        check("R11 held read", 1'b1, DNW);
        oe_n = 1'b1;
        #1;
        check("R10 oe high async", 1'b0, Z18);
        oe_n = 1'b0;
        #1;
        check("R10 oe low async", 1'b1, DNW);
        // R1: reset mid-burst, then continuations stay silent
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset mid-burst", 1'b0, Z18);
        rst_n = 1'b1;
        adv_n = 1'b0;
        for (int k = 0; k < 2; k++) begin
            @(posedge clk);
            @(negedge clk);
            check("R1 no burst after reset", 1'b0, Z18);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule